// File: doc/BRIEF.md
# Sneak-Current Reuse Read Sequencer

This block runs the read sequence for every sub-bank of one bank in a cross-point resistive memory array. An unselected cell in such an array leaks a background (sneak) current. A read therefore happens in two phases. In the first phase, half the read voltage is applied and the leakage of the target column is sampled into a sample-and-hold stage. In the second phase, the full read voltage is applied and the total current is sampled. The bit is decided by comparing the two samples. When the total is close to the background, the cell is in its high-resistance state and reads as 0.

The held background value can serve later reads that target the same column. For each sub-bank the sequencer records which column's leakage sample is still held, and whether that record is valid. A read that hits the held column skips the leakage phase and completes in the total-current phase alone. A write notice or an explicit invalidate for a sub-bank drops that sub-bank's record, because the held leakage may then be stale. Hit and miss counts are kept so that the column hit rate can be measured.

Requests arrive one at a time through a valid/ready handshake. Each result returns as a one-cycle pulse that carries the bit, a hit flag and the request's address.

Top module: `sneak_read_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, both counters are 0 and no sub-bank holds a column, so the first read to any sub-bank is a miss.
- R2: A request is taken only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the result cycle. Request inputs that change while busy do not affect the read in progress.
- R3: A miss drives `bg_phase` for T_BG cycles and then `total_phase` for T_RD cycles. `rd_valid` rises T_BG+T_RD cycles after the accepting edge.
- R4: A read whose sub-bank holds a valid record for the same column is a hit. It skips the background phase (no `bg_sample`) and `rd_valid` rises T_RD cycles after the accepting edge.
- R5: `bg_sample` is high for exactly one cycle, the last cycle of the background phase. `total_sample` is high for exactly one cycle, the last cycle of the total phase. The result follows in the next cycle.
- R6: `rd_data` is 1 when `sense_total` exceeds the held background value by more than MARGIN. Otherwise it is 0 (high-resistance state). On a hit, the held value is the one captured by the earlier miss. On a miss, it is `sense_bg` at the `bg_sample` cycle.
- R7: At the end of its background phase, a miss records its column, marks it valid and stores `sense_bg` for its own sub-bank only. The records of other sub-banks are unchanged.
- R8: `wr_seen` with `wr_sub`, or `inv_req` with `inv_sub`, clears the valid mark of that sub-bank, so the next read to it is a miss. When a clear and a capture reach the same sub-bank at the same edge, the clear wins.
- R9: `rd_valid` is a one-cycle pulse. It carries `rd_hit` and echoes the sub-bank, row and column that were accepted.
- R10: `hit_count` and `miss_count` each increase by one at every accepted hit or miss respectively, and saturate at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_sub | input | SB_W | Target sub-bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| wr_seen | input | 1 | A write was issued to sub-bank `wr_sub` |
| wr_sub | input | SB_W | Sub-bank of the write notice |
| inv_req | input | 1 | Drop the held record of `inv_sub` |
| inv_sub | input | SB_W | Sub-bank to invalidate |
| sense_bg | input | SENSE_W | Digitised background current |
| sense_total | input | SENSE_W | Digitised total current |
| bg_phase | output | 1 | Half-voltage leakage phase active |
| total_phase | output | 1 | Full-voltage phase active |
| bg_sample | output | 1 | Capture strobe, last leakage-phase cycle |
| total_sample | output | 1 | Capture strobe, last total-phase cycle |
| rd_valid | output | 1 | Result pulse |
| rd_data | output | 1 | Decided bit |
| rd_hit | output | 1 | Read reused a held background sample |
| rd_sub | output | SB_W | Sub-bank of the result |
| rd_row | output | ROW_W | Row of the result |
| rd_col | output | COL_W | Column of the result |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The bench builds the sequencer with 4 sub-banks, 4 columns, T_BG=3, T_RD=2, MARGIN=16 and 4-bit counters. It sweeps every sub-bank and column pair with a miss and then a hit, and it times each read against the phase lengths. The 4-bit counters let both counts reach their saturation value within the sweep. The small margin puts the decision boundary at totals of held+16 and held+17, and a clear can be timed to land on the capture edge itself.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BG   = 2'd1,
    ST_TOT  = 2'd2
  } srs_state_e;

  // Low-resistance cell: total current clears the held leakage by more than margin.
  function automatic logic srs_low_res(input logic [31:0] total,
                                       input logic [31:0] held,
                                       input logic [31:0] margin);
    return total > (held + margin);
  endfunction

  // Number of cycles a read spends from acceptance to its result.
  function automatic int unsigned srs_latency(input logic hit,
                                              input int unsigned t_bg,
                                              input int unsigned t_rd);
    return hit ? t_rd : (t_bg + t_rd);
  endfunction

endpackage

// File: rtl/srs_phase_timer.sv
module srs_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = run && (cnt_q == '0);
endmodule

// File: rtl/srs_sat_counter.sv
module srs_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (inc && cnt != '1)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srs_tag_table.sv
module srs_tag_table #(
  parameter int SUBS    = 32,
  parameter int COL_W   = 10,
  parameter int SENSE_W = 12,
  localparam int SB_W   = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SB_W-1:0]    lk_sub,
  output logic               lk_valid,
  output logic [COL_W-1:0]   lk_tag,
  input  logic [SB_W-1:0]    rd_sub,
  output logic [SENSE_W-1:0] rd_held,
  input  logic               cap_en,
  input  logic [SB_W-1:0]    cap_sub,
  input  logic [COL_W-1:0]   cap_tag,
  input  logic [SENSE_W-1:0] cap_held,
  input  logic               clr_a_en,
  input  logic [SB_W-1:0]    clr_a_sub,
  input  logic               clr_b_en,
  input  logic [SB_W-1:0]    clr_b_sub
);
  logic [SUBS-1:0]    valid_q;
  logic [COL_W-1:0]   tag_q  [SUBS];
  logic [SENSE_W-1:0] held_q [SUBS];

  for (genvar s = 0; s < SUBS; s++) begin : g_entry
    logic cap_me, clr_me;
    assign cap_me = cap_en && (cap_sub == SB_W'(s));
    assign clr_me = (clr_a_en && (clr_a_sub == SB_W'(s))) ||
                    (clr_b_en && (clr_b_sub == SB_W'(s)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        tag_q[s]   <= '0;
        held_q[s]  <= '0;
      end else begin
        if (clr_me)      valid_q[s] <= 1'b0;
        else if (cap_me) valid_q[s] <= 1'b1;
        if (cap_me) begin
          tag_q[s]  <= cap_tag;
          held_q[s] <= cap_held;
        end
      end
    end
  end

  assign lk_valid = valid_q[lk_sub];
  assign lk_tag   = tag_q[lk_sub];
  assign rd_held  = held_q[rd_sub];
endmodule

// File: rtl/sneak_read_seq.sv
module sneak_read_seq #(
  parameter int SUBS    = 32,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int SENSE_W = 12,
  parameter int T_BG    = 8,
  parameter int T_RD    = 6,
  parameter int MARGIN  = 64,
  parameter int CNT_W   = 32,
  localparam int SB_W   = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SB_W-1:0]    req_sub,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic               wr_seen,
  input  logic [SB_W-1:0]    wr_sub,
  input  logic               inv_req,
  input  logic [SB_W-1:0]    inv_sub,
  input  logic [SENSE_W-1:0] sense_bg,
  input  logic [SENSE_W-1:0] sense_total,
  output logic               bg_phase,
  output logic               total_phase,
  output logic               bg_sample,
  output logic               total_sample,
  output logic               rd_valid,
  output logic               rd_data,
  output logic               rd_hit,
  output logic [SB_W-1:0]    rd_sub,
  output logic [ROW_W-1:0]   rd_row,
  output logic [COL_W-1:0]   rd_col,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  import srs_pkg::*;

  localparam int TMAX = (T_BG > T_RD) ? T_BG : T_RD;
  localparam int TW   = $clog2(TMAX + 1);

  srs_state_e          state_q;
  logic [SB_W-1:0]     cur_sub;
  logic [ROW_W-1:0]    cur_row;
  logic [COL_W-1:0]    cur_col;
  logic                cur_hit;

  // Named internal events, also observed by the checker.
  logic                accept;
  logic                lookup_hit;
  logic                phase_last;
  logic                lk_valid;
  logic [COL_W-1:0]    lk_tag;
  logic [SENSE_W-1:0]  held_cur;
  logic                tmr_load;
  logic [TW-1:0]       tmr_val;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign lookup_hit   = lk_valid && (lk_tag == req_col);
  assign bg_phase     = (state_q == ST_BG);
  assign total_phase  = (state_q == ST_TOT);
  assign bg_sample    = bg_phase && phase_last;
  assign total_sample = total_phase && phase_last;
  assign tmr_load     = accept || bg_sample;
  assign tmr_val      = ((accept && lookup_hit) || bg_sample) ? TW'(T_RD - 1)
                                                              : TW'(T_BG - 1);

  srs_tag_table #(.SUBS(SUBS), .COL_W(COL_W), .SENSE_W(SENSE_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_sub   (req_sub),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag),
    .rd_sub   (cur_sub),
    .rd_held  (held_cur),
    .cap_en   (bg_sample),
    .cap_sub  (cur_sub),
    .cap_tag  (cur_col),
    .cap_held (sense_bg),
    .clr_a_en (wr_seen),
    .clr_a_sub(wr_sub),
    .clr_b_en (inv_req),
    .clr_b_sub(inv_sub)
  );

  srs_phase_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .run     (!req_ready),
    .last    (phase_last)
  );

  srs_sat_counter #(.W(CNT_W)) u_hits (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (accept && lookup_hit),
    .cnt  (hit_count)
  );

  srs_sat_counter #(.W(CNT_W)) u_misses (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (accept && !lookup_hit),
    .cnt  (miss_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_sub  <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_hit  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
      rd_hit   <= 1'b0;
      rd_sub   <= '0;
      rd_row   <= '0;
      rd_col   <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_sub <= req_sub;
          cur_row <= req_row;
          cur_col <= req_col;
          cur_hit <= lookup_hit;
          state_q <= lookup_hit ? ST_TOT : ST_BG;
        end
        ST_BG: if (phase_last) state_q <= ST_TOT;
        ST_TOT: if (phase_last) begin
          state_q  <= ST_IDLE;
          rd_valid <= 1'b1;
          rd_data  <= srs_low_res(32'(sense_total), 32'(held_cur), 32'(MARGIN));
          rd_hit   <= cur_hit;
          rd_sub   <= cur_sub;
          rd_row   <= cur_row;
          rd_col   <= cur_col;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             lookup_hit,
  input logic             bg_phase,
  input logic             total_phase,
  input logic             bg_sample,
  input logic             total_sample,
  input logic             rd_valid,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_result_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready);
  p_miss_enters_bg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !lookup_hit |=> bg_phase);
  p_phases_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bg_phase && total_phase));
  p_hit_skips_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && lookup_hit |=> total_phase && !bg_phase);
  p_bg_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bg_sample |=> !bg_sample && total_phase);
  p_total_then_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    total_sample |=> rd_valid);
  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_hits_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hit_count >= $past(hit_count));
  p_misses_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> miss_count >= $past(miss_count));
endmodule

bind sneak_read_seq srs_checker #(.CNT_W(CNT_W)) u_srs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .lookup_hit  (lookup_hit),
  .bg_phase    (bg_phase),
  .total_phase (total_phase),
  .bg_sample   (bg_sample),
  .total_sample(total_sample),
  .rd_valid    (rd_valid),
  .hit_count   (hit_count),
  .miss_count  (miss_count)
);

// File: tb/sneak_read_seq_bench.sv
`timescale 1ns/1ps
module sneak_read_seq_bench;
  localparam int SUBS = 4, ROW_W = 3, COL_W = 2, SENSE_W = 8;
  localparam int T_BG = 3, T_RD = 2, MARGIN = 16, CNT_W = 4;
  localparam int SB_W = 2;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [SB_W-1:0] req_sub = '0, wr_sub = '0, inv_sub = '0, rd_sub;
  logic [ROW_W-1:0] req_row = '0, rd_row;
  logic [COL_W-1:0] req_col = '0, rd_col;
  logic wr_seen = 1'b0, inv_req = 1'b0;
  logic [SENSE_W-1:0] sense_bg = '0, sense_total = '0;
  logic bg_phase, total_phase, bg_sample, total_sample;
  logic rd_valid, rd_data, rd_hit;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #2.5 clk = ~clk;

  sneak_read_seq #(.SUBS(SUBS), .ROW_W(ROW_W), .COL_W(COL_W), .SENSE_W(SENSE_W),
    .T_BG(T_BG), .T_RD(T_RD), .MARGIN(MARGIN), .CNT_W(CNT_W)) u_sneak_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sub(req_sub), .req_row(req_row), .req_col(req_col),
    .wr_seen(wr_seen), .wr_sub(wr_sub), .inv_req(inv_req), .inv_sub(inv_sub),
    .sense_bg(sense_bg), .sense_total(sense_total),
    .bg_phase(bg_phase), .total_phase(total_phase),
    .bg_sample(bg_sample), .total_sample(total_sample),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_hit(rd_hit),
    .rd_sub(rd_sub), .rd_row(rd_row), .rd_col(rd_col),
    .hit_count(hit_count), .miss_count(miss_count));

  int n_checks = 0, n_fail = 0;
  bit m_valid [SUBS];
  int m_tag [SUBS];
  int m_held [SUBS];
  int m_hits = 0, m_misses = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One read; noise scrambles the request inputs while busy, clr_bg lands an
  // invalidate for the same sub-bank on the capture edge.
  task automatic do_read(input int s, input int c, input int bg, input int tot,
                         input bit noise, input bit clr_bg);
    bit exp_hit;
    int lat, held_used, n, bg_pulses, tot_pulses, bg_pos, tot_pos;
    exp_hit   = m_valid[s] && (m_tag[s] == c);
    lat       = exp_hit ? T_RD : T_BG + T_RD;
    held_used = exp_hit ? m_held[s] : bg;
    @(negedge clk);
    req_sub = SB_W'(s); req_col = COL_W'(c); req_row = ROW_W'(s + c);
    sense_bg = SENSE_W'(bg); sense_total = SENSE_W'(tot);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!noise) req_valid = 1'b0;
    else begin
      req_sub = SB_W'(s + 1); req_col = COL_W'(c + 1); req_row = ROW_W'(s + c + 3);
    end
    if (exp_hit) begin if (m_hits < CMAX) m_hits++; end
    else if (m_misses < CMAX) m_misses++;
    n = 0; bg_pulses = 0; tot_pulses = 0; bg_pos = -1; tot_pos = -1;
    while (!rd_valid && n < 40) begin
      if (inv_req) inv_req = 1'b0;
      chk(req_ready == 1'b0, "R2 busy ready", req_ready, 0);
      if (bg_sample) begin
        bg_pulses++; bg_pos = n;
        if (clr_bg) begin inv_req = 1'b1; inv_sub = SB_W'(s); end
      end
      if (total_sample) begin tot_pulses++; tot_pos = n; end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    inv_req = 1'b0;
    chk(n == lat, exp_hit ? "R4 hit latency" : "R3 miss latency", n, lat);
    chk(rd_hit == exp_hit, "R4 hit flag", rd_hit, exp_hit);
    chk(bg_pulses == (exp_hit ? 0 : 1), "R5 bg strobe count", bg_pulses, exp_hit ? 0 : 1);
    if (!exp_hit) chk(bg_pos == T_BG - 1, "R5 bg strobe position", bg_pos, T_BG - 1);
    chk(tot_pulses == 1 && tot_pos == lat - 1, "R5 total strobe position", tot_pos, lat - 1);
    chk(rd_data == (tot > held_used + MARGIN), "R6 data", rd_data, tot > held_used + MARGIN);
    chk(rd_sub == SB_W'(s) && rd_col == COL_W'(c) && rd_row == ROW_W'(s + c),
        "R9 echo (R2 busy inputs ignored)", {rd_sub, rd_col}, (s << COL_W) | c);
    chk(hit_count == CNT_W'(m_hits), "R10 hit count", hit_count, m_hits);
    chk(miss_count == CNT_W'(m_misses), "R10 miss count", miss_count, m_misses);
    if (!exp_hit) begin
      m_tag[s] = c; m_held[s] = bg; m_valid[s] = !clr_bg;
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9 pulse width", rd_valid, 0);
  endtask

  task automatic clear_pulse(input bit w, input int ws, input bit i, input int is);
    @(negedge clk);
    wr_seen = w; wr_sub = SB_W'(ws); inv_req = i; inv_sub = SB_W'(is);
    @(negedge clk);
    wr_seen = 1'b0; inv_req = 1'b0;
    if (w) m_valid[ws] = 1'b0;
    if (i) m_valid[is] = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SUBS; s++) begin m_valid[s] = 0; m_tag[s] = 0; m_held[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0 && bg_phase == 1'b0 && total_phase == 1'b0,
        "R1 quiet after reset", rd_valid, 0);
    chk(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count + miss_count, 0);

    // R3 R4 R6 R7 R10: miss then hit on every sub-bank and column.
    for (int s = 0; s < SUBS; s++) begin
      for (int c = 0; c < 4; c++) begin
        int bg;
        bg = 20 + 10 * s + c;
        do_read(s, c, bg, bg + 40, 1'b0, 1'b0);
        do_read(s, c, bg + 7, bg + ((c % 2 == 1) ? 5 : 30), 1'b0, 1'b0);
      end
      if (s == 0) chk(hit_count == 4 && miss_count == 4, "R10 counts after first pass",
                      hit_count, 4);
    end
    chk(hit_count == CNT_W'(CMAX), "R10 hit saturation", hit_count, CMAX);
    chk(miss_count == CNT_W'(CMAX), "R10 miss saturation", miss_count, CMAX);

    // R6 boundary on a hit: held for sub 0 is 23.
    do_read(0, 3, 0, 23 + MARGIN, 1'b0, 1'b0);
    do_read(0, 3, 0, 23 + MARGIN + 1, 1'b0, 1'b0);
    // R6 miss whose total equals background: high-resistance.
    do_read(1, 0, 50, 50, 1'b0, 1'b0);
    // R2 inputs scrambled while busy; R7 records the accepted column.
    do_read(2, 0, 60, 90, 1'b1, 1'b0);
    do_read(2, 0, 0, 70, 1'b0, 1'b0);
    // R7 sub 3 still holds column 3 after other sub-banks were rewritten.
    do_read(3, 3, 0, 60, 1'b0, 1'b0);
    // R8 clear on the capture edge wins.
    do_read(2, 1, 40, 45, 1'b0, 1'b1);
    do_read(2, 1, 41, 80, 1'b0, 1'b0);
    // R8 write notice and invalidate, together on different sub-banks.
    clear_pulse(1'b1, 3, 1'b1, 0);
    do_read(3, 3, 30, 70, 1'b0, 1'b0);
    do_read(0, 3, 30, 31, 1'b0, 1'b0);
    do_read(1, 0, 0, 90, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule